// File: doc/BRIEF.md
# Masked Address-Match Debug Trigger

This block watches the transaction stream of a cache pipeline and raises two single-cycle debug pulses. Each cycle can carry one transaction: a valid bit, a 32-bit command word and a 40-bit physical address. Three bit fields are taken from that transaction and each is compared against a software-programmed compare register, after an AND with a software-programmed mask register. The first field is command bits [25:21], the second is command bits [18:13], and the third is address bits [33:2]. A match pulse is produced when every field agrees.

A second pulse reports error events. It fires when a programmed trigger enable is set and at least one of four watched error flags is active. Debug logic uses the two pulses to freeze trace capture or to signal an external analyser. Software programs the mask, the compare value and the trigger enable through three independent write ports.

Top module: `txn_watch_trigger`

## Requirements
- R1: While rstN is low on a clock edge, the block clears the mask register, the compare register, the trigger enable and the match pipeline. matchPulse and errEvent are low from the following cycle. With the cleared registers, every valid transaction matches.
- R2: Field A holds txnInst[25:21]. ANDed with mask bits [52:48], it must equal compare bits [52:48].
- R3: Field B holds txnInst[18:13]. ANDed with mask bits [45:40], it must equal compare bits [45:40].
- R4: Field C holds txnAddr[33:2]. ANDed with mask bits [33:2], it must equal compare bits [33:2].
- R5: A match needs txnValid high and all three fields equal. If txnValid is low, or any single field differs, no pulse is produced.
- R6: matchPulse is high in cycle k+2 exactly when a matching transaction was presented in cycle k. It is never high at any other time.
- R7: Matching transactions on consecutive cycles give matchPulse high on the same number of consecutive cycles.
- R8: A mask bit of 0 makes that transaction bit a don't-care. A compare bit of 1 under a mask bit of 0 makes the field impossible to match.
- R9: Mask and compare bits outside [52:48], [45:40] and [33:2] have no effect on matching. Command and address bits outside the three fields also have no effect.
- R10: errEvent is high in cycle k+1 exactly when, in cycle k, the trigger enable was set and at least one of these flags was 1: errStatus[36], errStatus[35], notData[49] or notData[48]. No other flag bit has an effect.
- R11: A value written on a clock edge (maskWrEn, cmpWrEn or trigWrEn high) applies to transactions and flags sampled on later edges. A transaction sampled on the same edge as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| maskWrEn | input | 1 | Loads maskWrData into the mask register |
| maskWrData | input | 64 | New mask value |
| cmpWrEn | input | 1 | Loads cmpWrData into the compare register |
| cmpWrData | input | 64 | New compare value |
| trigWrEn | input | 1 | Loads trigWrData into the trigger enable |
| trigWrData | input | 1 | New trigger enable value |
| txnValid | input | 1 | A transaction is present this cycle |
| txnInst | input | 32 | Transaction command word |
| txnAddr | input | 40 | Transaction physical address |
| errStatus | input | 64 | Error status word (bits 36 and 35 watched) |
| notData | input | 64 | Not-data status word (bits 49 and 48 watched) |
| matchPulse | output | 1 | Masked match, two cycles after the transaction |
| errEvent | output | 1 | Gated error event, one cycle after the flags |

## Verification
The assertions assume that txnValid, the field bits and the write enables are known (never X) on every clock edge after reset. They also assume that reset stays low long enough for the match pipeline to empty. The temporal checks then hold from the first edge with reset high. The stimulus drives every input at the falling edge and holds each value for a full cycle. It starts with a multi-cycle reset and never leaves a port undriven. The random phase builds compare values as subsets of the mask and copies compare fields into transactions, so many transactions hit without writes landing mid-window.

// File: rtl/txn_watch_pkg.sv
package txn_watch_pkg;

  localparam int InstW     = 32;
  localparam int AddrW     = 40;
  localparam int RegW      = 64;
  localparam int FlagW     = 64;
  localparam int NumFields = 3;
  localparam int MatchLat  = 2;

  // Field layout: position in the {address, command} source vector,
  // position in the mask/compare register, and width.
  localparam int FieldSrcBit [NumFields] = '{21, 13, InstW + 2};
  localparam int FieldRegBit [NumFields] = '{48, 40, 2};
  localparam int FieldWidth  [NumFields] = '{5, 6, 32};

  // Watched flag positions in the two error words.
  localparam int NumErrFlags = 2;
  localparam int ErrFlagBit     [NumErrFlags] = '{36, 35};
  localparam int NotDataFlagBit [NumErrFlags] = '{49, 48};

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic loadMask;
    logic loadCmp;
  } dpStrobesT;

endpackage

// File: rtl/txn_watch_dp.sv
module txn_watch_dp
  import txn_watch_pkg::*;
#(
  parameter int INST_W     = InstW,
  parameter int ADDR_W     = AddrW,
  parameter int REG_W      = RegW,
  parameter int NUM_FIELDS = NumFields
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobesT             strobes,
  input  logic [REG_W-1:0]      maskWrData,
  input  logic [REG_W-1:0]      cmpWrData,
  input  logic [INST_W-1:0]     txnInst,
  input  logic [ADDR_W-1:0]     txnAddr,
  output logic [NUM_FIELDS-1:0] fieldEq
);

  localparam int SrcW = INST_W + ADDR_W;

  logic [SrcW-1:0] srcVec;
  assign srcVec = {txnAddr, txnInst};

  // Only the field bits are stored; the rest of each write word is dropped.
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int W      = FieldWidth[f];
    localparam int RegLo  = FieldRegBit[f];
    localparam int SrcLo  = FieldSrcBit[f];

    logic [W-1:0] maskField;
    logic [W-1:0] cmpField;
    logic [W-1:0] srcField;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskField <= '0;
        cmpField  <= '0;
      end else begin
        if (strobes.loadMask) maskField <= maskWrData[RegLo +: W];
        if (strobes.loadCmp)  cmpField  <= cmpWrData[RegLo +: W];
      end
    end

    assign srcField   = srcVec[SrcLo +: W];
    assign fieldEq[f] = ((srcField & maskField) == cmpField);

    // R11: a write lands on the edge and is visible in the next cycle
    assert_mask_load_R11: assert property (@(posedge clk) disable iff (!rstN)
      strobes.loadMask |=> (maskField == $past(maskWrData[RegLo +: W])));
    assert_cmp_load_R11: assert property (@(posedge clk) disable iff (!rstN)
      strobes.loadCmp |=> (cmpField == $past(cmpWrData[RegLo +: W])));
    // R1: registers are clear after a reset edge
    assert_field_clear_R1: assert property (@(posedge clk)
      !rstN |=> (maskField == '0 && cmpField == '0));
  end

  // Bits outside the fields are intentionally not consumed.
  logic unusedBits;
  assign unusedBits = ^maskWrData ^ ^cmpWrData ^ ^srcVec;

endmodule

// File: rtl/txn_watch_ctrl.sv
module txn_watch_ctrl
  import txn_watch_pkg::*;
#(
  parameter int NUM_FIELDS = NumFields,
  parameter int FLAG_W     = FlagW,
  parameter int MATCH_LAT  = MatchLat
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  maskWrEn,
  input  logic                  cmpWrEn,
  input  logic                  trigWrEn,
  input  logic                  trigWrData,
  input  logic                  txnValid,
  input  logic [NUM_FIELDS-1:0] fieldEq,
  input  logic [FLAG_W-1:0]     errStatus,
  input  logic [FLAG_W-1:0]     notData,
  output dpStrobesT             strobes,
  output logic                  matchPulse,
  output logic                  errEvent
);

  assign strobes.loadMask = maskWrEn;
  assign strobes.loadCmp  = cmpWrEn;

  // Match pipeline: one bit per stage instead of delaying the transaction.
  logic hit;
  assign hit = txnValid && (&fieldEq);

  logic [MATCH_LAT-1:0] hitPipe;
  if (MATCH_LAT == 1) begin : g_lat_one
    always_ff @(posedge clk) begin
      if (!rstN) hitPipe <= '0;
      else       hitPipe <= hit;
    end
  end else begin : g_lat_many
    always_ff @(posedge clk) begin
      if (!rstN) hitPipe <= '0;
      else       hitPipe <= {hitPipe[MATCH_LAT-2:0], hit};
    end
  end
  assign matchPulse = hitPipe[MATCH_LAT-1];

  // Error event path.
  logic trigEn;
  always_ff @(posedge clk) begin
    if (!rstN)         trigEn <= 1'b0;
    else if (trigWrEn) trigEn <= trigWrData;
  end

  logic [2*NumErrFlags-1:0] flagHits;
  for (genvar i = 0; i < NumErrFlags; i++) begin : g_flags
    assign flagHits[i]               = errStatus[ErrFlagBit[i]];
    assign flagHits[NumErrFlags + i] = notData[NotDataFlagBit[i]];
  end

  logic anyFlag;
  assign anyFlag = |flagHits;

  logic errEventQ;
  always_ff @(posedge clk) begin
    if (!rstN) errEventQ <= 1'b0;
    else       errEventQ <= trigEn && anyFlag;
  end
  assign errEvent = errEventQ;

  logic unusedFlags;
  assign unusedFlags = ^errStatus ^ ^notData;

  // R1: reset clears both pulses and the trigger enable
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!matchPulse && !errEvent && !trigEn));

  if (MATCH_LAT == 2) begin : g_lat_checks
    // R6: a qualifying transaction is reported two cycles later
    assert_match_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
      (txnValid && (&fieldEq)) |-> ##2 matchPulse);
    // R5: a pulse always traces back to a valid transaction
    assert_match_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
      matchPulse |-> $past(txnValid, 2));
  end

  // R10: error event needs the enable and a watched flag one cycle earlier
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |-> ($past(trigEn) && $past(errStatus[ErrFlagBit[0]] || errStatus[ErrFlagBit[1]]
                  || notData[NotDataFlagBit[0]] || notData[NotDataFlagBit[1]])));
  assert_err_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    (trigEn && errStatus[ErrFlagBit[0]]) |=> errEvent);
  // R11: the enable takes the written value on the next cycle
  assert_trig_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    trigWrEn |=> (trigEn == $past(trigWrData)));

endmodule

// File: rtl/txn_watch_trigger.sv
module txn_watch_trigger
  import txn_watch_pkg::*;
#(
  parameter int INST_W    = InstW,
  parameter int ADDR_W    = AddrW,
  parameter int REG_W     = RegW,
  parameter int FLAG_W    = FlagW,
  parameter int MATCH_LAT = MatchLat
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              maskWrEn,
  input  logic [REG_W-1:0]  maskWrData,
  input  logic              cmpWrEn,
  input  logic [REG_W-1:0]  cmpWrData,
  input  logic              trigWrEn,
  input  logic              trigWrData,
  input  logic              txnValid,
  input  logic [INST_W-1:0] txnInst,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [FLAG_W-1:0] errStatus,
  input  logic [FLAG_W-1:0] notData,
  output logic              matchPulse,
  output logic              errEvent
);

  dpStrobesT             strobes;
  logic [NumFields-1:0]  fieldEq;

  txn_watch_ctrl #(
    .NUM_FIELDS (NumFields),
    .FLAG_W     (FLAG_W),
    .MATCH_LAT  (MATCH_LAT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .maskWrEn   (maskWrEn),
    .cmpWrEn    (cmpWrEn),
    .trigWrEn   (trigWrEn),
    .trigWrData (trigWrData),
    .txnValid   (txnValid),
    .fieldEq    (fieldEq),
    .errStatus  (errStatus),
    .notData    (notData),
    .strobes    (strobes),
    .matchPulse (matchPulse),
    .errEvent   (errEvent)
  );

  txn_watch_dp #(
    .INST_W     (INST_W),
    .ADDR_W     (ADDR_W),
    .REG_W      (REG_W),
    .NUM_FIELDS (NumFields)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .maskWrData (maskWrData),
    .cmpWrData  (cmpWrData),
    .txnInst    (txnInst),
    .txnAddr    (txnAddr),
    .fieldEq    (fieldEq)
  );

endmodule

// File: tb/txn_watch_trigger_bench.sv
module txn_watch_trigger_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        maskWrEn = 1'b0;
  logic [63:0] maskWrData = '0;
  logic        cmpWrEn = 1'b0;
  logic [63:0] cmpWrData = '0;
  logic        trigWrEn = 1'b0;
  logic        trigWrData = 1'b0;
  logic        txnValid = 1'b0;
  logic [31:0] txnInst = '0;
  logic [39:0] txnAddr = '0;
  logic [63:0] errStatus = '0;
  logic [63:0] notData = '0;
  logic        matchPulse;
  logic        errEvent;

  always #5 clk = ~clk;

  txn_watch_trigger u_txn_watch_trigger (
    .clk(clk), .rstN(rstN),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData),
    .trigWrEn(trigWrEn), .trigWrData(trigWrData),
    .txnValid(txnValid), .txnInst(txnInst), .txnAddr(txnAddr),
    .errStatus(errStatus), .notData(notData),
    .matchPulse(matchPulse), .errEvent(errEvent)
  );

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string curReq = "R1";

  // Behavioural reference model.
  logic [63:0] mMask = '0, mCmp = '0;
  bit          mTrig = 1'b0;
  bit          expMatch = 1'b0, expErr = 1'b0, mHit;
  bit          hitQ [$];

  function automatic bit fieldsOk(logic [63:0] m, logic [63:0] c,
                                  logic [31:0] i, logic [39:0] a);
    bit ok = 1'b1;
    if ((i[25:21] & m[52:48]) != c[52:48]) ok = 1'b0;
    if ((i[18:13] & m[45:40]) != c[45:40]) ok = 1'b0;
    if ((a[33:2]  & m[33:2])  != c[33:2])  ok = 1'b0;
    return ok;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = '0; mCmp = '0; mTrig = 1'b0;
      expMatch = 1'b0; expErr = 1'b0;
      hitQ = '{1'b0};
    end else begin
      mHit = txnValid && fieldsOk(mMask, mCmp, txnInst, txnAddr);
      expErr = mTrig && (errStatus[36] || errStatus[35] || notData[49] || notData[48]);
      expMatch = hitQ.pop_front();
      hitQ.push_back(mHit);
      if (maskWrEn) mMask = maskWrData;
      if (cmpWrEn)  mCmp  = cmpWrData;
      if (trigWrEn) mTrig = trigWrData;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks += 2;
      if (matchPulse !== expMatch) begin
        fails++;
        $display("FAIL %s matchPulse act=%0b exp=%0b at cycle %0d", curReq, matchPulse, expMatch, cycles);
      end
      if (errEvent !== expErr) begin
        fails++;
        $display("FAIL %s errEvent act=%0b exp=%0b at cycle %0d", curReq, errEvent, expErr, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog act=%0d cycles exp=completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mkInst(logic [4:0] a, logic [5:0] b, logic [31:0] noise);
    logic [31:0] r = noise;
    r[25:21] = a; r[18:13] = b;
    return r;
  endfunction

  function automatic logic [39:0] mkAddr(logic [31:0] c, logic [39:0] noise);
    logic [39:0] r = noise;
    r[33:2] = c;
    return r;
  endfunction

  function automatic logic [63:0] mkReg(logic [4:0] a, logic [5:0] b, logic [31:0] c, logic [63:0] noise);
    logic [63:0] r = noise;
    r[52:48] = a; r[45:40] = b; r[33:2] = c;
    return r;
  endfunction

  task automatic idle();
    maskWrEn = 1'b0; cmpWrEn = 1'b0; trigWrEn = 1'b0;
    txnValid = 1'b0; errStatus = '0; notData = '0;
  endtask

  task automatic txn(input logic v, input logic [31:0] i, input logic [39:0] a);
    @(negedge clk); idle();
    txnValid = v; txnInst = i; txnAddr = a;
  endtask

  task automatic wrRegs(input logic [63:0] m, input logic [63:0] c);
    @(negedge clk); idle();
    maskWrEn = 1'b1; maskWrData = m;
    cmpWrEn = 1'b1;  cmpWrData = c;
  endtask

  task automatic wrTrig(input logic t);
    @(negedge clk); idle();
    trigWrEn = 1'b1; trigWrData = t;
  endtask

  task automatic flags(input logic [63:0] es, input logic [63:0] nd);
    @(negedge clk); idle();
    errStatus = es; notData = nd;
  endtask

  task automatic drain();
    for (int k = 0; k < 3; k++) txn(1'b0, '0, '0);
  endtask

  initial begin
    // R1: reset with activity on the inputs
    curReq = "R1";
    txnValid = 1'b1; trigWrEn = 1'b1; trigWrData = 1'b1;
    errStatus = 64'h1 << 36;
    repeat (4) @(negedge clk);
    idle();
    rstN = 1'b1;
    txn(1'b1, 32'hDEADBEEF, 40'h12_3456_789A);
    txn(1'b1, 32'h0, 40'h0);
    flags(64'h1 << 36, 64'h0);
    drain();

    // R2: field A only
    curReq = "R2";
    wrRegs(mkReg(5'h1F, 6'h0, 32'h0, 64'h0), mkReg(5'h15, 6'h0, 32'h0, 64'h0));
    txn(1'b1, mkInst(5'h15, 6'h3F, 32'h0), 40'hFF_FFFF_FFFF);
    txn(1'b1, mkInst(5'h14, 6'h00, 32'h0), 40'h0);
    txn(1'b1, mkInst(5'h05, 6'h00, 32'h0), 40'h0);
    drain();

    // R3: field B only
    curReq = "R3";
    wrRegs(mkReg(5'h0, 6'h3F, 32'h0, 64'h0), mkReg(5'h0, 6'h2A, 32'h0, 64'h0));
    txn(1'b1, mkInst(5'h1F, 6'h2A, 32'h0), 40'h0);
    txn(1'b1, mkInst(5'h00, 6'h2B, 32'h0), 40'h0);
    txn(1'b1, mkInst(5'h00, 6'h0A, 32'h0), 40'h0);
    drain();

    // R4: field C only
    curReq = "R4";
    wrRegs(mkReg(5'h0, 6'h0, 32'hFFFF_FFFF, 64'h0), mkReg(5'h0, 6'h0, 32'hCAFE_1234, 64'h0));
    txn(1'b1, 32'hFFFF_FFFF, mkAddr(32'hCAFE_1234, 40'h0));
    txn(1'b1, 32'h0, mkAddr(32'hCAFE_1235, 40'h0));
    txn(1'b1, 32'h0, mkAddr(32'h4AFE_1234, 40'h0));
    drain();

    // R5: all fields, validity and single-field misses
    curReq = "R5";
    wrRegs(mkReg(5'h1F, 6'h3F, 32'hFFFF_FFFF, 64'h0), mkReg(5'h0A, 6'h11, 32'h0BAD_F00D, 64'h0));
    txn(1'b0, mkInst(5'h0A, 6'h11, 32'h0), mkAddr(32'h0BAD_F00D, 40'h0));
    txn(1'b1, mkInst(5'h0A, 6'h11, 32'h0), mkAddr(32'h0BAD_F00D, 40'h0));
    txn(1'b1, mkInst(5'h0B, 6'h11, 32'h0), mkAddr(32'h0BAD_F00D, 40'h0));
    txn(1'b1, mkInst(5'h0A, 6'h10, 32'h0), mkAddr(32'h0BAD_F00D, 40'h0));
    txn(1'b1, mkInst(5'h0A, 6'h11, 32'h0), mkAddr(32'h0BAD_F00C, 40'h0));
    drain();

    // R6: isolated hit, pulse only two cycles later
    curReq = "R6";
    txn(1'b1, mkInst(5'h0A, 6'h11, 32'h0), mkAddr(32'h0BAD_F00D, 40'h0));
    for (int k = 0; k < 5; k++) txn(1'b0, mkInst(5'h0A, 6'h11, 32'h0), mkAddr(32'h0BAD_F00D, 40'h0));

    // R7: back-to-back hits, then alternating
    curReq = "R7";
    for (int k = 0; k < 4; k++) txn(1'b1, mkInst(5'h0A, 6'h11, 32'h0), mkAddr(32'h0BAD_F00D, 40'h0));
    for (int k = 0; k < 6; k++) txn(1'b1, mkInst(5'h0A, 6'h11, 32'h0), mkAddr(32'h0BAD_F00D ^ (k % 2), 40'h0));
    drain();

    // R8: partial mask, and compare bit outside the mask
    curReq = "R8";
    wrRegs(mkReg(5'h10, 6'h01, 32'h0000_00FF, 64'h0), mkReg(5'h10, 6'h01, 32'h0000_0012, 64'h0));
    txn(1'b1, mkInst(5'h1F, 6'h3F, 32'h0), mkAddr(32'hFFFF_FF12, 40'h0));
    txn(1'b1, mkInst(5'h10, 6'h01, 32'h0), mkAddr(32'h1234_5612, 40'h0));
    wrRegs(mkReg(5'h10, 6'h01, 32'h0000_00FF, 64'h0), mkReg(5'h18, 6'h01, 32'h0000_0012, 64'h0));
    txn(1'b1, mkInst(5'h18, 6'h01, 32'h0), mkAddr(32'h12, 40'h0));
    txn(1'b1, mkInst(5'h1F, 6'h3F, 32'h0), mkAddr(32'hFF, 40'h0));
    drain();

    // R9: bits outside the fields have no effect
    curReq = "R9";
    wrRegs(64'hFFFF_FFFF_FFFF_FFFF, mkReg(5'h03, 6'h22, 32'h8000_0001, 64'h8000_8000_0000_0003));
    txn(1'b1, mkInst(5'h03, 6'h22, 32'hFC01_1FFF), mkAddr(32'h8000_0001, 40'hFC_0000_0003));
    txn(1'b1, mkInst(5'h03, 6'h22, 32'h0), mkAddr(32'h8000_0001, 40'h0));
    drain();

    // R10: error event gating
    curReq = "R10";
    flags(64'h1 << 36, 64'h1 << 49);
    wrTrig(1'b1);
    flags(64'h1 << 36, 64'h0);
    flags(64'h1 << 35, 64'h0);
    flags(64'h0, 64'h1 << 49);
    flags(64'h0, 64'h1 << 48);
    flags(~((64'h1 << 36) | (64'h1 << 35)), ~((64'h1 << 49) | (64'h1 << 48)));
    flags(64'h0, 64'h0);
    wrTrig(1'b0);
    flags(64'h1 << 35, 64'h1 << 48);
    drain();

    // R11: writes apply only from the next edge on
    curReq = "R11";
    @(negedge clk); idle();
    maskWrEn = 1'b1; maskWrData = 64'hFFFF_FFFF_FFFF_FFFF;
    cmpWrEn = 1'b1;  cmpWrData = mkReg(5'h1, 6'h1, 32'h1, 64'h0);
    txnValid = 1'b1; txnInst = mkInst(5'h1, 6'h1, 32'h0); txnAddr = mkAddr(32'h1, 40'h0);
    txn(1'b1, mkInst(5'h1, 6'h1, 32'h0), mkAddr(32'h1, 40'h0));
    @(negedge clk); idle();
    maskWrEn = 1'b1; maskWrData = 64'h0;
    cmpWrEn = 1'b1;  cmpWrData = 64'h0;
    txnValid = 1'b1; txnInst = 32'h0; txnAddr = 40'h0;
    txn(1'b1, 32'h0, 40'h0);
    @(negedge clk); idle();
    trigWrEn = 1'b1; trigWrData = 1'b1; errStatus = 64'h1 << 36;
    flags(64'h1 << 36, 64'h0);
    drain();

    // Mixed random traffic against the model (R5, R6, R7, R10)
    curReq = "R5";
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] rm, rc;
      @(negedge clk); idle();
      if ($urandom_range(0, 15) == 0) begin
        rm = {$urandom(), $urandom()};
        if ($urandom_range(0, 1) == 1) rm = rm | mkReg(5'h1F, 6'h3F, 32'hFFFF_FFFF, 64'h0);
        rc = rm & {$urandom(), $urandom()};
        maskWrEn = 1'b1; maskWrData = rm;
        cmpWrEn = 1'b1;  cmpWrData = rc;
      end
      if ($urandom_range(0, 31) == 0) begin
        trigWrEn = 1'b1; trigWrData = 1'($urandom_range(0, 1));
      end
      txnValid = 1'($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) != 0) begin
        txnInst = mkInst(mCmp[52:48], mCmp[45:40], $urandom());
        txnAddr = mkAddr(mCmp[33:2], {$urandom(), $urandom()});
        if ($urandom_range(0, 7) == 0) txnAddr[2 + $urandom_range(0, 31)] ^= 1'b1;
      end else begin
        txnInst = $urandom();
        txnAddr = {$urandom(), $urandom()};
      end
      errStatus = 64'h1 << $urandom_range(33, 38);
      notData = 64'h1 << $urandom_range(46, 51);
    end
    drain();

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule